// File: doc/BRIEF.md
# Pipelined Remote Access Tracker

This block sits between a local requester and a long-latency remote link. Read and write operations go out on the link request stream as soon as they are accepted, with no wait for earlier operations to finish. Each accepted operation is recorded in an in-order tracking queue. Completions from the far side come back as configuration-space writes on the reply stream. A reply that targets the implementation half of that 16-bit space (bit 15 set) retires the oldest tracked operation. The block absorbs the reply and turns it into one local response, so the reply never shows up as a local bus write.

Only one data port width is accepted. The width is fixed by the `DW` parameter. An operation whose size code differs from it is never sent to the link. It still takes its place in the queue, and when it reaches the head it retires locally with an error, so responses stay in issue order. A small configuration read port exposes the control half of the space. It gives a 32-deep history of per-operation error bits, a sticky protocol-error flag for replies that arrive when nothing is outstanding, and the current queue occupancy.

Top module: `remote_op_tracker`

## Requirements
- R1: An accepted operation with a matching size is presented on the link request stream in the same cycle. Operations are accepted back to back with no replies in between, in any mix of reads and writes, up to `DEPTH` (16) held. With `DEPTH` held, `lreq_ready_o` is low. For a matching size it also follows `tx_ready_i`.
- R2: Each accepted reply with `rx_addr_i[15]`=1 retires the oldest held operation. `lrsp_valid_o` is high for exactly the following cycle, and `lrsp_we_o` equals that operation's type.
- R3: A read completion returns the reply data on `lrsp_rdata_o`. A write completion returns zero. `lrsp_err_o` equals the reply's `rx_err_i`.
- R4: `rx_ready_o` is high except while the oldest held entry is a locally failed operation. Accepted replies never create link request traffic.
- R5: A reply with `rx_addr_i[15]`=0 (control region) is consumed. It retires nothing and gives no response.
- R6: Size codes are 0 for 8, 1 for 16, 2 for 32 and 3 for 64 bits. An operation whose `lreq_size_i` is not log2(`DW`/8) (2 by default) is accepted whenever the queue has room and is never forwarded. It retires in order one cycle after it reaches the head, with `lrsp_err_o`=1 and zero data, and needs no reply.
- R7: A configuration read of 0x0004 returns the error history. Bit 0 is the newest completion (1 = error) and older results move toward bit 31. It updates on the same edge that raises `lrsp_valid_o`.
- R8: A reply with `rx_addr_i[15]`=1 while nothing is held is dropped with no response. It sets a protocol-error flag, read as bit 0 at 0x0008, which stays set until reset.
- R9: A configuration read of 0x0008 returns the occupancy in bits 12:8 (default depth) and the protocol-error flag in bit 0, with all other bits zero.
- R10: Configuration reads of any other address, in either region, return zero.
- R11: After reset no operation is held, `lrsp_valid_o` is low, the history and status read zero, and `lreq_ready_o` and `rx_ready_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lreq_valid_i | input | 1 | Local operation valid |
| lreq_ready_o | output | 1 | Local operation accepted |
| lreq_we_i | input | 1 | 1 write, 0 read |
| lreq_size_i | input | 2 | Port size code |
| lreq_addr_i | input | AW | Remote bus address |
| lreq_wdata_i | input | DW | Write data |
| tx_valid_o | output | 1 | Link request valid |
| tx_ready_i | input | 1 | Link request ready |
| tx_we_o | output | 1 | Link request type |
| tx_addr_o | output | AW | Link request address |
| tx_wdata_o | output | DW | Link request data |
| rx_valid_i | input | 1 | Reply valid |
| rx_ready_o | output | 1 | Reply accepted |
| rx_addr_i | input | 16 | Reply configuration address |
| rx_data_i | input | DW | Reply data |
| rx_err_i | input | 1 | Remote bus error |
| lrsp_valid_o | output | 1 | Local response strobe |
| lrsp_we_o | output | 1 | Type of retired operation |
| lrsp_rdata_o | output | DW | Read result |
| lrsp_err_o | output | 1 | Operation failed |
| cfg_addr_i | input | 16 | Configuration read address |
| cfg_rdata_o | output | 32 | Configuration read data |

## Verification
The bound checker watches, on every cycle, the rules that relate a single cycle to the next. A full queue refuses new work. A wrong-size operation never reaches the link. An accepted implementation-region reply produces a response one cycle later when work is held, and a control-region reply into an empty queue produces none. A stray reply sets the protocol flag, and the flag stays set. The history shifts exactly when a response appears. Issue order against completion order, read data routing, the in-order local retirement of wrong-size entries behind real ones, and the content of the history word over many completions can only be shown by the bench. Its scenarios cover back-to-back write-then-read and interleaved traffic, a full queue, link back-pressure, control-region and stray replies, and a behavioural queue model that is compared every cycle.

// File: rtl/rop_pkg.sv
package rop_pkg;
  typedef struct packed {
    logic we;    // operation is a write
    logic lerr;  // retired locally with error, never sent
  } op_ent_t;

  localparam logic [15:0] CFG_HIST_ADDR = 16'h0004;
  localparam logic [15:0] CFG_STAT_ADDR = 16'h0008;
  localparam int          STAT_CNT_LSB  = 8;
endpackage

// File: rtl/rop_fifo.sv
module rop_fifo #(
  parameter int W     = 2,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr];
  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign count_o = cnt;
endmodule

// File: rtl/rop_issue.sv
module rop_issue
  import rop_pkg::*;
#(
  parameter logic [1:0] SIZE_CODE = 2'd2
) (
  input  logic       lreq_valid_i,
  input  logic       lreq_we_i,
  input  logic [1:0] lreq_size_i,
  input  logic       tx_ready_i,
  input  logic       full_i,
  output logic       lreq_ready_o,
  output logic       tx_valid_o,
  output logic       push_o,
  output op_ent_t    ent_o
);
  logic size_ok;

  assign size_ok      = (lreq_size_i == SIZE_CODE);
  // wrong-size work needs only a queue slot, never the link
  assign lreq_ready_o = !full_i && (!size_ok || tx_ready_i);
  assign tx_valid_o   = lreq_valid_i && size_ok && !full_i;
  assign push_o       = lreq_valid_i && lreq_ready_o;
  assign ent_o.we     = lreq_we_i;
  assign ent_o.lerr   = !size_ok;
endmodule

// File: rtl/rop_retire.sv
module rop_retire
  import rop_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic          rx_impl_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_err_i,
  input  logic          empty_i,
  input  op_ent_t       head_i,
  output logic          rx_ready_o,
  output logic          pop_o,
  output logic          done_err_o,
  output logic          lrsp_valid_o,
  output logic          lrsp_we_o,
  output logic [DW-1:0] lrsp_rdata_o,
  output logic          lrsp_err_o,
  output logic          perr_o
);
  logic head_lerr, rx_done, stray;

  assign head_lerr  = !empty_i && head_i.lerr;
  assign rx_ready_o = !head_lerr;
  assign rx_done    = rx_valid_i && rx_ready_o && rx_impl_i;
  assign pop_o      = head_lerr || (rx_done && !empty_i);
  assign stray      = rx_done && empty_i;
  assign done_err_o = head_lerr || rx_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lrsp_valid_o <= 1'b0;
      lrsp_we_o    <= 1'b0;
      lrsp_rdata_o <= '0;
      lrsp_err_o   <= 1'b0;
      perr_o       <= 1'b0;
    end else begin
      lrsp_valid_o <= pop_o;
      if (pop_o) begin
        lrsp_we_o    <= head_i.we;
        lrsp_err_o   <= done_err_o;
        lrsp_rdata_o <= (head_lerr || head_i.we) ? '0 : rx_data_i;
      end
      if (stray) perr_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rop_cfg.sv
module rop_cfg
  import rop_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          done_err_i,
  input  logic [CW-1:0] count_i,
  input  logic          perr_i,
  input  logic [15:0]   cfg_addr_i,
  output logic [31:0]   cfg_rdata_o,
  output logic [31:0]   hist_o
);
  logic [31:0] stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hist_o <= '0;
    else if (done_i) hist_o <= {hist_o[30:0], done_err_i};
  end

  always_comb begin
    stat                     = '0;
    stat[STAT_CNT_LSB +: CW] = count_i;
    stat[0]                  = perr_i;
  end

  always_comb begin
    case (cfg_addr_i)
      CFG_HIST_ADDR: cfg_rdata_o = hist_o;
      CFG_STAT_ADDR: cfg_rdata_o = stat;
      default:       cfg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/remote_op_tracker.sv
module remote_op_tracker
  import rop_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lreq_valid_i,
  output logic          lreq_ready_o,
  input  logic          lreq_we_i,
  input  logic [1:0]    lreq_size_i,
  input  logic [AW-1:0] lreq_addr_i,
  input  logic [DW-1:0] lreq_wdata_i,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic          tx_we_o,
  output logic [AW-1:0] tx_addr_o,
  output logic [DW-1:0] tx_wdata_o,
  input  logic          rx_valid_i,
  output logic          rx_ready_o,
  input  logic [15:0]   rx_addr_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_err_i,
  output logic          lrsp_valid_o,
  output logic          lrsp_we_o,
  output logic [DW-1:0] lrsp_rdata_o,
  output logic          lrsp_err_o,
  input  logic [15:0]   cfg_addr_i,
  output logic [31:0]   cfg_rdata_o
);
  localparam int         CW        = $clog2(DEPTH + 1);
  localparam logic [1:0] SIZE_CODE = 2'($clog2(DW / 8));

  op_ent_t       push_ent, head;
  logic          push, pop, full, empty, done_err, perr;
  logic [CW-1:0] occ;
  logic [31:0]   hist;
  logic          unused_rx_addr;

  assign unused_rx_addr = ^rx_addr_i[14:0];

  assign tx_we_o    = lreq_we_i;
  assign tx_addr_o  = lreq_addr_i;
  assign tx_wdata_o = lreq_wdata_i;

  rop_issue #(.SIZE_CODE(SIZE_CODE)) u_issue (
    .lreq_valid_i (lreq_valid_i),
    .lreq_we_i    (lreq_we_i),
    .lreq_size_i  (lreq_size_i),
    .tx_ready_i   (tx_ready_i),
    .full_i       (full),
    .lreq_ready_o (lreq_ready_o),
    .tx_valid_o   (tx_valid_o),
    .push_o       (push),
    .ent_o        (push_ent)
  );

  rop_fifo #(.W($bits(op_ent_t)), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (push_ent),
    .pop_i   (pop),
    .head_o  (head),
    .full_o  (full),
    .empty_o (empty),
    .count_o (occ)
  );

  rop_retire #(.DW(DW)) u_retire (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_valid_i   (rx_valid_i),
    .rx_impl_i    (rx_addr_i[15]),
    .rx_data_i    (rx_data_i),
    .rx_err_i     (rx_err_i),
    .empty_i      (empty),
    .head_i       (head),
    .rx_ready_o   (rx_ready_o),
    .pop_o        (pop),
    .done_err_o   (done_err),
    .lrsp_valid_o (lrsp_valid_o),
    .lrsp_we_o    (lrsp_we_o),
    .lrsp_rdata_o (lrsp_rdata_o),
    .lrsp_err_o   (lrsp_err_o),
    .perr_o       (perr)
  );

  rop_cfg #(.CW(CW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (pop),
    .done_err_i  (done_err),
    .count_i     (occ),
    .perr_i      (perr),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_rdata_o (cfg_rdata_o),
    .hist_o      (hist)
  );
endmodule

// File: rtl/rop_checker.sv
module rop_checker #(
  parameter int         DEPTH     = 16,
  parameter int         CW        = 5,
  parameter logic [1:0] SIZE_CODE = 2'd2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          lreq_valid_i,
  input logic [1:0]    lreq_size_i,
  input logic          lreq_ready_o,
  input logic          tx_valid_o,
  input logic          rx_valid_i,
  input logic          rx_ready_o,
  input logic          rx_impl_i,
  input logic          lrsp_valid_o,
  input logic [CW-1:0] count_i,
  input logic          perr_i,
  input logic [31:0]   hist_i
);
  assert_full_stalls_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == CW'(DEPTH)) |-> !lreq_ready_o);

  assert_reply_retires_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o && rx_impl_i && count_i != '0) |=> lrsp_valid_o);

  assert_ctrl_reply_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o && !rx_impl_i && count_i == '0) |=> !lrsp_valid_o);

  assert_bad_size_no_tx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lreq_valid_i && lreq_size_i != SIZE_CODE) |-> !tx_valid_o);

  assert_hist_shift_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrsp_valid_o |-> (hist_i[31:1] == $past(hist_i[30:0])));

  assert_stray_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o && rx_impl_i && count_i == '0) |=> (perr_i && !lrsp_valid_o));

  assert_perr_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_i |=> perr_i);
endmodule

bind remote_op_tracker rop_checker #(
  .DEPTH(DEPTH), .CW(CW), .SIZE_CODE(SIZE_CODE)
) u_rop_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lreq_valid_i (lreq_valid_i),
  .lreq_size_i  (lreq_size_i),
  .lreq_ready_o (lreq_ready_o),
  .tx_valid_o   (tx_valid_o),
  .rx_valid_i   (rx_valid_i),
  .rx_ready_o   (rx_ready_o),
  .rx_impl_i    (rx_addr_i[15]),
  .lrsp_valid_o (lrsp_valid_o),
  .count_i      (occ),
  .perr_i       (perr),
  .hist_i       (hist)
);

// File: tb/remote_op_tracker_bench.sv
module remote_op_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam logic [1:0] SZ = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lreq_valid, lreq_we, tx_ready, rx_valid, rx_err;
  logic [1:0]  lreq_size;
  logic [31:0] lreq_addr, lreq_wdata, rx_data;
  logic [15:0] rx_addr, cfg_addr;
  logic        lreq_ready_o, tx_valid_o, tx_we_o, rx_ready_o;
  logic        lrsp_valid_o, lrsp_we_o, lrsp_err_o;
  logic [31:0] tx_addr_o, tx_wdata_o, lrsp_rdata_o, cfg_rdata_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  remote_op_tracker u_remote_op_tracker (
    .clk_i(clk), .rst_ni(rst_n),
    .lreq_valid_i(lreq_valid), .lreq_ready_o(lreq_ready_o), .lreq_we_i(lreq_we),
    .lreq_size_i(lreq_size), .lreq_addr_i(lreq_addr), .lreq_wdata_i(lreq_wdata),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready), .tx_we_o(tx_we_o),
    .tx_addr_o(tx_addr_o), .tx_wdata_o(tx_wdata_o),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready_o), .rx_addr_i(rx_addr),
    .rx_data_i(rx_data), .rx_err_i(rx_err),
    .lrsp_valid_o(lrsp_valid_o), .lrsp_we_o(lrsp_we_o),
    .lrsp_rdata_o(lrsp_rdata_o), .lrsp_err_o(lrsp_err_o),
    .cfg_addr_i(cfg_addr), .cfg_rdata_o(cfg_rdata_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural model
  bit        q_we[$];
  bit        q_le[$];
  bit [31:0] m_hist = '0;
  bit        m_perr = 1'b0;
  bit        m_vld = 1'b0, m_we, m_err, m_rx_taken;
  bit [31:0] m_data;
  int        cyc = 0;
  logic [15:0] cfg_pick [6] = '{16'h0004, 16'h0008, 16'h0000, 16'h8000, 16'hFFFF, 16'h7FFC};

  function automatic logic [31:0] exp_cfg(input logic [15:0] a);
    if (a == 16'h0004) return m_hist;
    if (a == 16'h0008) return (32'(q_we.size()) << 8) | 32'(m_perr);
    return 32'h0;
  endfunction

  function automatic string cfg_tag(input logic [15:0] a);
    if (a == 16'h0004) return "R7";
    if (a == 16'h0008) return "R9";
    return "R10";
  endfunction

  task automatic step();
    bit full, hl, sok, lrdy, push;
    cfg_addr = cfg_pick[cyc % 6];
    cyc++;
    #1;
    full = (q_we.size() == DEPTH);
    hl   = (q_we.size() > 0) && q_le[0];
    sok  = (lreq_size == SZ);
    lrdy = !full && (!sok || tx_ready);
    push = lreq_valid && lrdy;
    chk("R1", "lreq_ready", 32'(lreq_ready_o), 32'(lrdy));
    chk("R1", "tx_valid", 32'(tx_valid_o), 32'(lreq_valid && sok && !full));
    if (lreq_valid && sok && !full) chk("R1", "tx_addr", tx_addr_o, lreq_addr);
    chk("R4", "rx_ready", 32'(rx_ready_o), 32'(!hl));
    chk(cfg_tag(cfg_addr), "cfg_rdata", cfg_rdata_o, exp_cfg(cfg_addr));
    @(posedge clk);
    m_vld      = 1'b0;
    m_rx_taken = rx_valid && !hl;
    if (hl) begin
      m_vld = 1'b1; m_we = q_we[0]; m_err = 1'b1; m_data = '0;
      void'(q_we.pop_front()); void'(q_le.pop_front());
    end else if (rx_valid && rx_addr[15]) begin
      if (q_we.size() == 0) m_perr = 1'b1;
      else begin
        m_vld = 1'b1; m_we = q_we[0]; m_err = rx_err;
        m_data = q_we[0] ? 32'h0 : rx_data;
        void'(q_we.pop_front()); void'(q_le.pop_front());
      end
    end
    if (m_vld) m_hist = {m_hist[30:0], m_err};
    if (push) begin
      q_we.push_back(lreq_we);
      q_le.push_back(!sok);
    end
    @(negedge clk);
    chk("R2", "lrsp_valid", 32'(lrsp_valid_o), 32'(m_vld));
    if (m_vld) begin
      chk("R2", "lrsp_we", 32'(lrsp_we_o), 32'(m_we));
      chk("R3", "lrsp_rdata", lrsp_rdata_o, m_data);
      chk("R3", "lrsp_err", 32'(lrsp_err_o), 32'(m_err));
    end
  endtask

  task automatic set_req(input logic we, input logic [31:0] a, input logic [31:0] d,
                         input logic [1:0] s);
    lreq_valid = 1'b1; lreq_we = we; lreq_addr = a; lreq_wdata = d; lreq_size = s;
  endtask

  task automatic issue(input logic we, input logic [31:0] a, input logic [31:0] d,
                       input logic [1:0] s);
    set_req(we, a, d, s);
    step();
    lreq_valid = 1'b0;
  endtask

  task automatic reply(input logic [15:0] a, input logic [31:0] d, input logic e);
    rx_valid = 1'b1; rx_addr = a; rx_data = d; rx_err = e;
    for (int t = 0; t < 4; t++) begin
      step();
      if (m_rx_taken) break;
    end
    rx_valid = 1'b0;
  endtask

  task automatic peek_cfg(input logic [15:0] a, input logic [31:0] exp, input string tag);
    cfg_addr = a;
    #1;
    chk(tag, "cfg peek", cfg_rdata_o, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lreq_valid = 0; lreq_we = 0; lreq_size = SZ; lreq_addr = 0; lreq_wdata = 0;
    tx_ready = 1; rx_valid = 0; rx_err = 0; rx_addr = 0; rx_data = 0; cfg_addr = 16'h0004;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11", "lrsp_valid", 32'(lrsp_valid_o), 0);
    chk("R11", "lreq_ready", 32'(lreq_ready_o), 1);
    chk("R11", "rx_ready", 32'(rx_ready_o), 1);
    chk("R11", "hist", cfg_rdata_o, 0);
    peek_cfg(16'h0008, 32'h0, "R11");

    // writes then reads, back to back (R1), then in-order replies (R2, R3)
    for (int i = 0; i < 4; i++) issue(1'b1, 32'h1000 + 32'(4 * i), 32'(i), SZ);
    for (int i = 0; i < 4; i++) issue(1'b0, 32'h2000 + 32'(4 * i), 32'h0, SZ);
    reply(16'h8000, 32'hA000_0000, 1'b0);
    chk("R4", "no tx from reply", 32'(tx_valid_o), 0);
    for (int i = 1; i < 8; i++) reply(16'h8000 + 16'(i), 32'hA000_0000 + 32'(i), 1'b0);

    // interleaved write/read with replies in the same cycles (R1, R2)
    issue(1'b1, 32'h3000, 32'h55, SZ);
    issue(1'b0, 32'h3004, 32'h0, SZ);
    for (int k = 0; k < 6; k++) begin
      set_req(k[0] == 1'b0, 32'h3100 + 32'(k), 32'(k), SZ);
      rx_valid = 1'b1; rx_addr = 16'h8001; rx_data = 32'hB000_0000 + 32'(k); rx_err = k[1];
      step();
      lreq_valid = 1'b0; rx_valid = 1'b0;
    end
    reply(16'h8002, 32'hC1, 1'b0);
    reply(16'h8003, 32'hC2, 1'b1);

    // fill to depth, stall, then drain with mixed errors (R1, R7)
    for (int i = 0; i < DEPTH + 1; i++) issue(i[0], 32'h4000 + 32'(i), 32'(i), SZ);
    peek_cfg(16'h0008, 32'(DEPTH) << 8, "R1");
    for (int i = 0; i < DEPTH; i++) reply(16'hF000, 32'hD000_0000 + 32'(i), (i % 3) == 0);

    // link back-pressure (R1)
    tx_ready = 1'b0;
    issue(1'b0, 32'h5000, 32'h0, SZ);
    tx_ready = 1'b1;

    // wrong-size operation between two good ones (R6)
    issue(1'b1, 32'h6000, 32'h77, SZ);
    set_req(1'b0, 32'h6004, 32'h0, 2'd0);
    #1;
    chk("R6", "bad size not forwarded", 32'(tx_valid_o), 0);
    step();
    lreq_valid = 1'b0;
    issue(1'b0, 32'h6008, 32'h0, SZ);
    reply(16'h8010, 32'h0, 1'b0);
    step();
    chk("R6", "local error rsp valid", 32'(lrsp_valid_o), 1);
    chk("R6", "local error rsp err", 32'(lrsp_err_o), 1);
    chk("R6", "local error rsp data", lrsp_rdata_o, 0);
    reply(16'h8011, 32'hE0E0, 1'b0);

    // control-region reply retires nothing (R5, R9)
    issue(1'b0, 32'h7000, 32'h0, SZ);
    issue(1'b0, 32'h7004, 32'h0, SZ);
    reply(16'h0010, 32'h1234, 1'b0);
    chk("R5", "ctrl reply no rsp", 32'(lrsp_valid_o), 0);
    peek_cfg(16'h0008, 32'h2 << 8, "R9");
    reply(16'h8020, 32'h11, 1'b0);
    reply(16'h8021, 32'h22, 1'b0);

    // stray reply with nothing held (R8)
    reply(16'h8030, 32'h99, 1'b1);
    chk("R8", "stray no rsp", 32'(lrsp_valid_o), 0);
    peek_cfg(16'h0008, 32'h1, "R8");
    issue(1'b0, 32'h7100, 32'h0, SZ);
    reply(16'h8031, 32'h44, 1'b0);
    peek_cfg(16'h0008, 32'h1, "R8");
    repeat (3) step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule